// File: doc/BRIEF.md
# Four-Line Serial PCM Port

This block sits between four serial PCM lines and a delay core. All lines share one bit clock and one word clock. A word lasts 64 bit clocks and holds a left slot and a right slot of 32 clocks each, so the four lines carry eight channels. On the receive side the block turns each completed word into eight parallel samples and hands them to the core. On the transmit side it takes eight samples back and shifts them out on four output lines.

A polarity input selects which word-clock edge starts a word. A bypass input routes each input line straight to its output line. An active-high disable input turns off the output drivers, and a per-channel mute forces a channel to zero. Bypass, disable and mute take effect only from the next word. The pad tri-state is driven from the `sdout_en` output.

The capture side has no back-pressure. A sample set is offered for one cycle when `cap_valid` pulses, and the core must take it then. The playback side uses a handshake: `play_ready` pulses for one cycle per word, and a sample set is taken when `play_valid` is high in that cycle. If `play_valid` is low, the next output word is silent.

Top module: `sap_port`

## Requirements
- R1: A word is 64 bit clocks. One cycle after each `play_ready` pulse, `cap_valid` pulses for one cycle and `cap_data` holds the word just completed. Channel c = 2*line + side occupies `cap_data[c*SW +: SW]`. Side 0 is the left slot, which is the first 32 bits after the word boundary. Side 1 is the right slot.
- R2: Input bits are sampled on the rising bit-clock edge, MSB first. Each captured sample is the top SW bits of its 32-bit slot, and the remaining slot bits are ignored. Between `cap_valid` pulses, `cap_data` does not change.
- R3: With `wpol` high, a word starts at a rising word-clock edge and the left slot is the high phase. With `wpol` low, a word starts at a falling edge and the left slot is the low phase. Capture and playback work the same under either setting.
- R4: `play_ready` is high for exactly one cycle per word: the cycle before the rising edge that samples the word's last bit. A set offered with `play_valid` is sent in the following word. Each sample is sent MSB first, left-justified in its slot, with zero padding. Output bits change on the falling bit-clock edge.
- R5: If `play_valid` is low when `play_ready` is high, every bit of the next output word is zero.
- R6: A channel whose `mute` bit is high at the transfer is sent as all zeros in the next word. Unmuted channels are not affected.
- R7: While bypass is in force, each output line equals its input line with no delay.
- R8: `bypass`, `oe_n` and `mute` are sampled only on the rising edge at the end of a word. A change in the middle of a word does not alter that word's output. `sdout_en` changes only right after that edge.
- R9: While `oe_n` was high at the last word end, `sdout_en` is low and `sdout` is zero for the whole word.
- R10: While `rst_n` is low, `sdout_en`, `cap_valid` and `play_ready` are low. After release, the block locks on the first word boundary it sees. It raises `play_ready` first at the end of that word, and outputs stay disabled through that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bck | input | 1 | Bit clock, 64 per word |
| rst_n | input | 1 | Asynchronous active-low reset |
| wck | input | 1 | Word clock |
| wpol | input | 1 | Word-boundary polarity: 1 rising / left high, 0 falling / left low |
| sdin | input | LANES | Serial input lines |
| cap_valid | output | 1 | One-cycle strobe: `cap_data` holds a new word |
| cap_data | output | 2*LANES*SW | Captured samples, channel c at `[c*SW +: SW]` |
| play_ready | output | 1 | One-cycle strobe: playback set is taken this cycle |
| play_valid | input | 1 | Playback set present |
| play_data | input | 2*LANES*SW | Playback samples, same channel layout |
| bypass | input | 1 | Route inputs directly to outputs (word-aligned) |
| oe_n | input | 1 | Disable output drivers (word-aligned) |
| mute | input | 2*LANES | Per-channel zero forcing (word-aligned) |
| sdout | output | LANES | Serial output lines, zero when disabled |
| sdout_en | output | 1 | Output driver enable for the pads |

## Verification
Capture of the completed input word, loading of the next output word and sampling of the word-aligned controls all fall on the same rising edge, at the last bit of a word. The bench changes the capture pattern, the playback set and the control inputs together in every table entry. It then checks the captured set, the whole next output word and the enable flag after that shared edge. Two entries toggle bypass in the middle of a word, and the bench confirms that the current word is unchanged.

// File: rtl/sap_pkg.sv
package sap_pkg;

  // Word-aligned control state applied to the output lines.
  typedef struct packed {
    logic byp;  // outputs follow inputs
    logic dis;  // drivers off
  } word_ctl_t;

  localparam word_ctl_t CTL_RESET = '{byp: 1'b0, dis: 1'b1};

endpackage

// File: rtl/sap_wclk_align.sv
// Word-boundary detection and bit position counter.
module sap_wclk_align #(
  parameter int FRAME_BITS = 64
) (
  input  logic bck,
  input  logic rst_n,
  input  logic wck,
  input  logic wpol,
  output logic word_end
);
  localparam int CW = $clog2(FRAME_BITS);
  localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);

  logic          wck_q;
  logic          seen;
  logic          locked;
  logic [CW-1:0] cnt;
  logic          bnd;

  // First edge after reset only records the word clock level.
  always_comb begin
    if (wpol) bnd = seen && wck && !wck_q;
    else      bnd = seen && !wck && wck_q;
  end

  always_ff @(posedge bck or negedge rst_n) begin
    if (!rst_n) begin
      wck_q  <= 1'b0;
      seen   <= 1'b0;
      locked <= 1'b0;
      cnt    <= '0;
    end else begin
      wck_q <= wck;
      seen  <= 1'b1;
      if (bnd) begin
        locked <= 1'b1;
        cnt    <= CW'(1);
      end else if (cnt == LAST) begin
        cnt <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  // cnt holds the index of the bit sampled at the coming edge.
  assign word_end = locked && (cnt == LAST);

endmodule

// File: rtl/sap_rx_lane.sv
// One input line: shift in a word, split it into two samples.
module sap_rx_lane #(
  parameter int SLOT_BITS = 32,
  parameter int SW        = 24
) (
  input  logic          bck,
  input  logic          rst_n,
  input  logic          sdin,
  input  logic          word_end,
  output logic [SW-1:0] left,
  output logic [SW-1:0] right
);
  localparam int FB = 2 * SLOT_BITS;

  logic [FB-2:0] sr;
  logic [FB-1:0] full;

  assign full = {sr, sdin};

  always_ff @(posedge bck or negedge rst_n) begin
    if (!rst_n) begin
      sr    <= '0;
      left  <= '0;
      right <= '0;
    end else begin
      sr <= full[FB-2:0];
      if (word_end) begin
        left  <= full[FB-1 -: SW];
        right <= full[SLOT_BITS-1 -: SW];
      end
    end
  end

endmodule

// File: rtl/sap_tx_lane.sv
// One output line: load a word at word end, drive bits on the falling edge.
module sap_tx_lane #(
  parameter int SLOT_BITS = 32,
  parameter int SW        = 24
) (
  input  logic          bck,
  input  logic          rst_n,
  input  logic          word_end,
  input  logic [SW-1:0] left_in,
  input  logic [SW-1:0] right_in,
  output logic          pin
);
  localparam int FB  = 2 * SLOT_BITS;
  localparam int PAD = SLOT_BITS - SW;

  logic [SLOT_BITS-1:0] lslot;
  logic [SLOT_BITS-1:0] rslot;
  logic [FB-1:0]        sr;

  assign lslot = SLOT_BITS'(left_in)  << PAD;
  assign rslot = SLOT_BITS'(right_in) << PAD;

  always_ff @(posedge bck or negedge rst_n) begin
    if (!rst_n)        sr <= '0;
    else if (word_end) sr <= {lslot, rslot};
    else               sr <= {sr[FB-2:0], 1'b0};
  end

  always_ff @(negedge bck or negedge rst_n) begin
    if (!rst_n) pin <= 1'b0;
    else        pin <= sr[FB-1];
  end

endmodule

// File: rtl/sap_port.sv
module sap_port
  import sap_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int SLOT_BITS = 32,
  parameter int SW        = 24
) (
  input  logic                    bck,
  input  logic                    rst_n,
  input  logic                    wck,
  input  logic                    wpol,
  input  logic [LANES-1:0]        sdin,
  output logic                    cap_valid,
  output logic [2*LANES*SW-1:0]   cap_data,
  output logic                    play_ready,
  input  logic                    play_valid,
  input  logic [2*LANES*SW-1:0]   play_data,
  input  logic                    bypass,
  input  logic                    oe_n,
  input  logic [2*LANES-1:0]      mute,
  output logic [LANES-1:0]        sdout,
  output logic                    sdout_en
);
  localparam int FB = 2 * SLOT_BITS;

  logic       word_end;
  logic [LANES-1:0] pin;
  word_ctl_t  ctl_stg;
  word_ctl_t  ctl_act;

  sap_wclk_align #(.FRAME_BITS(FB)) u_align (
    .bck      (bck),
    .rst_n    (rst_n),
    .wck      (wck),
    .wpol     (wpol),
    .word_end (word_end)
  );

  assign play_ready = word_end;

  always_ff @(posedge bck or negedge rst_n) begin
    if (!rst_n) cap_valid <= 1'b0;
    else        cap_valid <= word_end;
  end

  // Controls sampled at word end, applied from the falling edge that starts the next word.
  always_ff @(posedge bck or negedge rst_n) begin
    if (!rst_n)        ctl_stg <= CTL_RESET;
    else if (word_end) ctl_stg <= '{byp: bypass, dis: oe_n};
  end

  always_ff @(negedge bck or negedge rst_n) begin
    if (!rst_n) ctl_act <= CTL_RESET;
    else        ctl_act <= ctl_stg;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int CL = 2 * l;
    localparam int CR = 2 * l + 1;
    logic [SW-1:0] tx_l;
    logic [SW-1:0] tx_r;

    sap_rx_lane #(.SLOT_BITS(SLOT_BITS), .SW(SW)) u_rx (
      .bck      (bck),
      .rst_n    (rst_n),
      .sdin     (sdin[l]),
      .word_end (word_end),
      .left     (cap_data[CL*SW +: SW]),
      .right    (cap_data[CR*SW +: SW])
    );

    assign tx_l = (play_valid && !mute[CL]) ? play_data[CL*SW +: SW] : '0;
    assign tx_r = (play_valid && !mute[CR]) ? play_data[CR*SW +: SW] : '0;

    sap_tx_lane #(.SLOT_BITS(SLOT_BITS), .SW(SW)) u_tx (
      .bck      (bck),
      .rst_n    (rst_n),
      .word_end (word_end),
      .left_in  (tx_l),
      .right_in (tx_r),
      .pin      (pin[l])
    );

    assign sdout[l] = ctl_act.dis ? 1'b0 : (ctl_act.byp ? sdin[l] : pin[l]);
  end

  assign sdout_en = !ctl_act.dis;

endmodule

// File: rtl/sap_port_chk.sv
module sap_port_chk #(
  parameter int DW = 192
) (
  input logic          bck,
  input logic          rst_n,
  input logic          play_ready,
  input logic          cap_valid,
  input logic [DW-1:0] cap_data,
  input logic          sdout_en
);

  assert_ready_pulse_R4: assert property (@(posedge bck) disable iff (!rst_n)
    play_ready |=> !play_ready);

  assert_cap_follows_R1: assert property (@(posedge bck) disable iff (!rst_n)
    play_ready |=> cap_valid);

  assert_cap_hold_R2: assert property (@(posedge bck) disable iff (!rst_n)
    !cap_valid |-> $stable(cap_data));

  assert_en_word_R8: assert property (@(posedge bck) disable iff (!rst_n)
    !$past(play_ready) |-> $stable(sdout_en));

endmodule

bind sap_port sap_port_chk #(.DW(2*LANES*SW)) u_chk (
  .bck        (bck),
  .rst_n      (rst_n),
  .play_ready (play_ready),
  .cap_valid  (cap_valid),
  .cap_data   (cap_data),
  .sdout_en   (sdout_en)
);

// File: tb/sim_sap_port.sv
module sim_sap_port;
  localparam int LANES = 4;
  localparam int SW    = 24;
  localparam int CH    = 2 * LANES;

  typedef struct packed {
    logic       wpol;
    logic       byp;
    logic       oen;
    logic       pv;
    logic       flip;
    logic [7:0] mute;
    logic [7:0] seed;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'd11},
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'hA5, 8'd22},
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'd33},
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'd44},
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'd55},
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h0F, 8'd66},
    '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 8'd77},
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'hFF, 8'd88}
  };

  logic                 bck = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 wck = 1'b0;
  logic                 wpol = 1'b1;
  logic [LANES-1:0]     sdin = '0;
  logic                 cap_valid;
  logic [CH*SW-1:0]     cap_data;
  logic                 play_ready;
  logic                 play_valid = 1'b0;
  logic [CH*SW-1:0]     play_data = '0;
  logic                 bypass = 1'b0;
  logic                 oe_n = 1'b0;
  logic [CH-1:0]        mute = '0;
  logic [LANES-1:0]     sdout;
  logic                 sdout_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [63:0]          in_fr [LANES];
  logic [63:0]          in_a  [LANES];
  logic [SW-1:0]        play_w [CH];
  logic [LANES*64-1:0]  got_fr;
  logic [LANES*64-1:0]  exp_fr;
  logic [CH*SW-1:0]     cap_got;
  logic [CH*SW-1:0]     cap_exp;
  logic                 cap_seen, ready_seen, en_all, en_any;
  vec_t                 t;
  string                otag;

  always #10 bck = ~bck;

  sap_port #(.LANES(LANES), .SLOT_BITS(32), .SW(SW)) u0 (
    .bck(bck), .rst_n(rst_n), .wck(wck), .wpol(wpol), .sdin(sdin),
    .cap_valid(cap_valid), .cap_data(cap_data),
    .play_ready(play_ready), .play_valid(play_valid), .play_data(play_data),
    .bypass(bypass), .oe_n(oe_n), .mute(mute),
    .sdout(sdout), .sdout_en(sdout_en)
  );

  function automatic logic [31:0] mix(input logic [31:0] s, input logic [31:0] i);
    logic [31:0] x;
    x = (s * 32'h9E3779B1) ^ ((i + 32'd1) * 32'h85EBCA6B);
    x = x ^ (x >> 15);
    x = x * 32'h2C1B3C6D;
    x = x ^ (x >> 12);
    return x;
  endfunction

  task automatic check(input string tag, input logic [255:0] got, input logic [255:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic fill_frame(input logic [31:0] seed);
    for (int l = 0; l < LANES; l++)
      in_fr[l] = {mix(seed, 2 * l), mix(seed, 2 * l + 1)};
  endtask

  // One word: inputs driven after each falling edge, outputs sampled 5 ns later.
  task automatic do_frame(input logic flip);
    en_all = 1'b1;
    en_any = 1'b0;
    for (int k = 0; k < 64; k++) begin
      @(negedge bck);
      wck = (k < 32) ? wpol : ~wpol;
      for (int l = 0; l < LANES; l++) sdin[l] = in_fr[l][63-k];
      if (flip && k == 20) bypass = ~bypass;
      #5;
      for (int l = 0; l < LANES; l++) got_fr[l*64 + 63 - k] = sdout[l];
      en_all = en_all & sdout_en;
      en_any = en_any | sdout_en;
      if (k == 0) begin
        cap_seen = cap_valid;
        cap_got  = cap_data;
      end
      if (k == 63) ready_seen = play_ready;
    end
  endtask

  task automatic reset_phase();
    rst_n = 1'b0;
    wck = ~wpol;
    sdin = '0;
    bypass = 1'b0;
    oe_n = 1'b0;
    mute = '0;
    play_valid = 1'b0;
    repeat (4) @(negedge bck);
    #5;
    // R10: everything quiet while in reset
    check("R10 reset state", {253'd0, sdout_en, cap_valid, play_ready}, 256'd0);
    @(negedge bck);
    rst_n = 1'b1;
    repeat (3) @(negedge bck);
    fill_frame(32'd999);
    do_frame(1'b0);
    check("R10 outputs off in first word", {255'd0, en_any}, 256'd0);
    check("R10 no capture before first word", {255'd0, cap_seen}, 256'd0);
    check("R10 first ready at end of locked word", {255'd0, ready_seen}, 256'd1);
  endtask

  initial begin
    repeat (20000) @(posedge bck);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    reset_phase();

    for (int v = 0; v < 8; v++) begin
      t = VEC[v];
      wpol       = t.wpol;
      bypass     = t.byp;
      oe_n       = t.oen;
      mute       = t.mute;
      play_valid = t.pv;
      for (int c = 0; c < CH; c++) begin
        logic [31:0] m;
        m = mix(32'(t.seed) + 32'd200, c);
        play_w[c] = m[SW-1:0];
        play_data[c*SW +: SW] = play_w[c];
      end

      // Word A: controls and playback set are taken at its end.
      fill_frame(32'(t.seed));
      for (int l = 0; l < LANES; l++) in_a[l] = in_fr[l];
      do_frame(1'b0);
      check("R4 ready at word end", {255'd0, ready_seen}, 256'd1);

      // Word B: observe capture of A and the output built from A's settings.
      fill_frame(32'(t.seed) + 32'd100);
      do_frame(t.flip);

      for (int l = 0; l < LANES; l++) begin
        cap_exp[(2*l)*SW   +: SW] = in_a[l][63 -: SW];
        cap_exp[(2*l+1)*SW +: SW] = in_a[l][31 -: SW];
      end
      if (t.wpol) check("R1 R2 captured samples", {63'd0, cap_seen, cap_exp ^ cap_got ^ cap_exp}, {63'd0, 1'b1, cap_exp});
      else        check("R3 captured samples low polarity", {63'd0, cap_seen, cap_got}, {63'd0, 1'b1, cap_exp});

      for (int l = 0; l < LANES; l++) begin
        if (t.oen) exp_fr[l*64 +: 64] = 64'd0;
        else if (t.byp) exp_fr[l*64 +: 64] = in_fr[l];
        else begin
          for (int s = 0; s < 2; s++) begin
            int c;
            c = 2 * l + s;
            exp_fr[l*64 + 32*(1-s) +: 32] =
              (t.pv && !t.mute[c]) ? {play_w[c], 8'h00} : 32'd0;
          end
        end
      end
      if (t.flip)           otag = "R8 mid-word toggle ignored";
      else if (t.oen)       otag = "R9 disabled output";
      else if (t.byp)       otag = "R7 bypass";
      else if (!t.pv)       otag = "R5 underrun silence";
      else if (t.mute != 0) otag = "R6 channel mute";
      else                  otag = "R4 playback word";
      check(otag, {{(256-LANES*64){1'b0}}, got_fr}, {{(256-LANES*64){1'b0}}, exp_fr});
      check("R9 driver enable", {254'd0, en_any, en_all}, t.oen ? 256'd0 : 256'd3);
    end

    // Directed: reset in the middle of operation, then re-lock.
    reset_phase();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule